// File: doc/BRIEF.md
# ADC Output Demultiplexer and Decimator

This block takes the sample stream of a converter core (one offset-binary sample per clock, qualified by a valid strobe and a per-sample over-range strobe) and presents it on two parallel output ports, named primary and auxiliary. Two static mode inputs choose the output word rate. In full-rate mode every sample goes to the primary port. In half-rate mode samples are paired across both ports. In quarter-rate mode every second sample is dropped first and the survivors are then paired.

Each new output word is marked by a one-cycle data-ready strobe. An over-range flag travels with the primary sample. A reset marker stays high for the first output word period after reset. Phase state for pairing and decimation starts from a known point after reset and after any change of mode, so the downstream capture logic always sees a predictable order.

Top module: `adc_demux_decim`

## Requirements
- R1: Mode decode: `demux_en_i`=0 selects full rate (DIV1); `demux_en_i`=1 with `div_sel_i`=0 selects half rate (DIV2); `demux_en_i`=1 with `div_sel_i`=1 selects quarter rate (DIV4).
- R2: Sample bits pass to the ports unchanged in offset binary. Bit 0 is the LSB on both the input and the ports.
- R3: In DIV1, each valid sample appears on `pri_data_o` in the cycle after it is accepted, and `aux_data_o` holds its value.
- R4: In DIV2, valid samples are taken in pairs. The earlier sample of a pair appears on `aux_data_o` and the later one on `pri_data_o`. Both ports update together in the cycle after the later sample is accepted.
- R5: In DIV4, counting valid samples from reset or from the last mode change, the 1st, 3rd, 5th and later odd-numbered samples are kept and the others are discarded. Kept samples are paired as in R4.
- R6: `dready_o` is high for exactly one cycle, in the cycle in which the ports present a new word. It is low in all other cycles.
- R7: `ovr_o` carries the over-range strobe of the sample shown on `pri_data_o`. It changes only when a new word is presented.
- R8: `rst_out_o` rises with the first word presented after reset and falls when the next word is presented.
- R9: A cycle with `sample_vld_i` low is ignored. It advances no phase, discards nothing and updates no output.
- R10: A change of the decoded mode clears the pair and decimation phases. The valid sample in the cycle of the change is the first sample of a new pair and is kept.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| demux_en_i | input | 1 | Demultiplexer enable mode pin |
| div_sel_i | input | 1 | Divide select mode pin |
| sample_i | input | 8 | Offset-binary sample from the converter core |
| sample_vld_i | input | 1 | Sample valid strobe |
| ovr_i | input | 1 | Over-range strobe for the current sample |
| pri_data_o | output | 8 | Primary port data |
| aux_data_o | output | 8 | Auxiliary port data |
| dready_o | output | 1 | Data-ready strobe, one cycle per output word |
| ovr_o | output | 1 | Over-range flag of the primary sample |
| rst_out_o | output | 1 | Marks the first output word after reset |

## Verification
The bench goes after gaps in the valid strobe in every mode. A design that advanced its phase on an idle cycle would swap the primary and auxiliary samples, or in DIV4 would keep the wrong sample. Mode changes in the middle of a pair check that the phase restarts; a design that kept the old phase would emit a word made from a stale auxiliary sample. The over-range flag is driven on samples that end up on the auxiliary port or that DIV4 discards; a flag taken from the wrong sample would show up there. A second reset in the middle of the run checks that the reset marker lasts exactly one word period and rises again after the new reset.

// File: rtl/adc_dmx_pkg.sv
package adc_dmx_pkg;
  typedef enum logic [1:0] {
    MODE_DIV1 = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2
  } dmx_mode_e;

  function automatic dmx_mode_e decode_mode(input logic en, input logic sel);
    if (!en)     return MODE_DIV1;
    else if (sel) return MODE_DIV4;
    else          return MODE_DIV2;
  endfunction
endpackage

// File: rtl/adc_dmx_mode_dec.sv
module adc_dmx_mode_dec
  import adc_dmx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      demux_en_i,
  input  logic      div_sel_i,
  output dmx_mode_e mode_o,
  output logic      mode_chg_o
);
  dmx_mode_e mode_q;

  assign mode_o     = decode_mode(demux_en_i, div_sel_i);
  assign mode_chg_o = (mode_o != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_DIV1;
    else         mode_q <= mode_o;
  end

  // R1: the decoded mode is never the unused code
  p_mode_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (demux_en_i && div_sel_i) |-> (mode_o == MODE_DIV4));
endmodule

// File: rtl/adc_dmx_decim.sv
module adc_dmx_decim
  import adc_dmx_pkg::*;
#(
  parameter int unsigned DECIM = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  dmx_mode_e mode_i,
  input  logic      mode_chg_i,
  input  logic      vld_i,
  output logic      keep_o
);
  localparam int unsigned CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_eff, cnt_nxt;
  logic             decim_act;

  assign decim_act = (mode_i == MODE_DIV4);
  assign cnt_eff   = mode_chg_i ? '0 : cnt_q;
  assign cnt_nxt   = (cnt_eff == CNT_W'(DECIM - 1)) ? '0 : cnt_eff + 1'b1;
  assign keep_o    = vld_i && (!decim_act || cnt_eff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (vld_i && decim_act) cnt_q <= cnt_nxt;
    else if (mode_chg_i) cnt_q <= '0;
  end

  // R5: a kept sample in DIV4 is never followed directly by another kept one
  p_single_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decim_act && keep_o) |=> !(keep_o && mode_i == MODE_DIV4 && !mode_chg_i));
endmodule

// File: rtl/adc_dmx_pair.sv
module adc_dmx_pair
  import adc_dmx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dmx_mode_e         mode_i,
  input  logic              mode_chg_i,
  input  logic              keep_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ovr_i,
  output logic              word_vld_o,
  output logic [DATA_W-1:0] pri_o,
  output logic [DATA_W-1:0] aux_o,
  output logic              aux_we_o,
  output logic              ovr_o
);
  logic              ph_q, ph_eff, split;
  logic [DATA_W-1:0] hold_q;

  assign split      = (mode_i != MODE_DIV1);
  assign ph_eff     = mode_chg_i ? 1'b0 : ph_q;
  assign word_vld_o = keep_i && (!split || ph_eff);
  assign pri_o      = sample_i;
  assign aux_o      = hold_q;
  assign aux_we_o   = split;
  assign ovr_o      = ovr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      if (keep_i && split) ph_q <= !ph_eff;
      else if (mode_chg_i) ph_q <= 1'b0;
      if (keep_i && split && !ph_eff) hold_q <= sample_i;
    end
  end

  // R4: a paired word always needs a fresh earlier sample first
  p_no_back_to_back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && split) |=> !(word_vld_o && mode_i != MODE_DIV1));
endmodule

// File: rtl/adc_demux_decim.sv
module adc_demux_decim
  import adc_dmx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DECIM  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              demux_en_i,
  input  logic              div_sel_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_vld_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] pri_data_o,
  output logic [DATA_W-1:0] aux_data_o,
  output logic              dready_o,
  output logic              ovr_o,
  output logic              rst_out_o
);
  dmx_mode_e         mode;
  logic              mode_chg, keep, word_vld, aux_we, w_ovr;
  logic [DATA_W-1:0] w_pri, w_aux;
  logic              first_q;

  adc_dmx_mode_dec i_mode_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .demux_en_i (demux_en_i),
    .div_sel_i  (div_sel_i),
    .mode_o     (mode),
    .mode_chg_o (mode_chg)
  );

  adc_dmx_decim #(.DECIM(DECIM)) i_decim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .mode_chg_i (mode_chg),
    .vld_i      (sample_vld_i),
    .keep_o     (keep)
  );

  adc_dmx_pair #(.DATA_W(DATA_W)) i_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .mode_chg_i (mode_chg),
    .keep_i     (keep),
    .sample_i   (sample_i),
    .ovr_i      (ovr_i),
    .word_vld_o (word_vld),
    .pri_o      (w_pri),
    .aux_o      (w_aux),
    .aux_we_o   (aux_we),
    .ovr_o      (w_ovr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_data_o <= '0;
      aux_data_o <= '0;
      dready_o   <= 1'b0;
      ovr_o      <= 1'b0;
      rst_out_o  <= 1'b0;
      first_q    <= 1'b1;
    end else begin
      dready_o <= word_vld;
      if (word_vld) begin
        pri_data_o <= w_pri;
        ovr_o      <= w_ovr;
        rst_out_o  <= first_q;
        first_q    <= 1'b0;
        if (aux_we) aux_data_o <= w_aux;
      end
    end
  end

  // R3: aux port frozen while running at full rate
  p_aux_hold_div1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DIV1 && $past(mode == MODE_DIV1)) |-> $stable(aux_data_o));
  // R8: reset marker only rises with a word
  p_rst_with_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_out_o) |-> dready_o);
  // R9: an idle input cycle never yields a word
  p_idle_no_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> !dready_o);
  // R7: flag moves only with a word
  p_ovr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dready_o |-> $stable(ovr_o));
endmodule

// File: tb/test_adc_demux_decim.sv
`timescale 1ns/1ps
module test_adc_demux_decim;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, sel = 1'b0, vld = 1'b0, ovr = 1'b0;
  logic [7:0] smp = '0;
  logic [7:0] pri, aux;
  logic       dr, ovr_q, rst_o;

  int checks = 0, errors = 0;

  // model state
  int         m_prev = 0, m_cnt = 0, m_ph = 0;
  logic [7:0] m_hold = '0, e_pri = '0, e_aux = '0;
  logic       e_dr = 0, e_ovr = 0, e_rst = 0, m_first = 1;

  always #2.5 clk = ~clk;

  adc_demux_decim i_adc_demux_decim (
    .clk_i(clk), .rst_ni(rst_n), .demux_en_i(en), .div_sel_i(sel),
    .sample_i(smp), .sample_vld_i(vld), .ovr_i(ovr),
    .pri_data_o(pri), .aux_data_o(aux), .dready_o(dr),
    .ovr_o(ovr_q), .rst_out_o(rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 R4 R5 pri", pri, e_pri);
    chk("R3 R4 aux", aux, e_aux);
    chk("R6 dready", dr, e_dr);
    chk("R7 ovr", ovr_q, e_ovr);
    chk("R8 rst_out", rst_o, e_rst);
  endtask

  task automatic model_reset();
    m_prev = 0; m_cnt = 0; m_ph = 0; m_hold = '0; m_first = 1;
    e_pri = '0; e_aux = '0; e_dr = 0; e_ovr = 0; e_rst = 0;
  endtask

  // R1 decode: en=0 -> 0 (DIV1), en=1 sel=0 -> 1 (DIV2), en=1 sel=1 -> 2 (DIV4)
  function automatic int mode_of(input logic e, input logic s);
    return !e ? 0 : (s ? 2 : 1);
  endfunction

  task automatic model_step();
    int  md;
    bit  keep, word;
    logic [7:0] p, a;
    md = mode_of(en, sel);
    if (md != m_prev) begin m_cnt = 0; m_ph = 0; end  // R10
    m_prev = md;
    word = 0; p = e_pri; a = e_aux;
    if (vld) begin
      keep = (md != 2) || (m_cnt == 0);
      if (md == 2) m_cnt = (m_cnt + 1) % 2;
      if (keep) begin
        if (md == 0) begin word = 1; p = smp; end
        else if (m_ph == 0) begin m_hold = smp; m_ph = 1; end
        else begin word = 1; p = smp; a = m_hold; m_ph = 0; end
      end
    end
    e_dr = word;
    if (word) begin
      e_pri = p; e_aux = a; e_ovr = ovr; e_rst = m_first; m_first = 0;
    end
  endtask

  task automatic drive(input logic e, input logic s, input logic v,
                       input logic [7:0] d, input logic o);
    @(negedge clk);
    en = e; sel = s; vld = v; smp = d; ovr = o;
    model_step();
    @(posedge clk); #1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 0;
    model_reset();
    #1;
    // R11: outputs clear while reset is low
    chk("R11 pri", pri, 0); chk("R11 aux", aux, 0); chk("R11 dready", dr, 0);
    chk("R11 ovr", ovr_q, 0); chk("R11 rst_out", rst_o, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R3 R8: full rate, first word raises rst_out
    drive(0, 0, 1, 8'h80, 0);
    drive(0, 0, 1, 8'h01, 1);
    drive(0, 0, 1, 8'hFF, 0);
    // R9: idle cycles in full rate
    drive(0, 0, 0, 8'h55, 1);
    drive(0, 0, 1, 8'h7F, 0);
    // R4 R10: switch to DIV2, pair with gap
    drive(1, 0, 1, 8'hA1, 1);
    drive(1, 0, 0, 8'h00, 0);
    drive(1, 0, 1, 8'hB2, 0);
    drive(1, 0, 1, 8'hC3, 0);
    drive(1, 0, 1, 8'hD4, 1);
    // R10: mode change mid pair to DIV4
    drive(1, 0, 1, 8'hE5, 0);
    drive(1, 1, 1, 8'h11, 0);
    drive(1, 1, 1, 8'h22, 1);  // R5 discarded, flag must not appear
    drive(1, 1, 0, 8'h33, 0);
    drive(1, 1, 1, 8'h44, 0);
    drive(1, 1, 1, 8'h55, 0);
    drive(1, 1, 1, 8'h66, 1);
    drive(1, 1, 1, 8'h77, 0);
    drive(1, 1, 1, 8'h88, 1);
    // R3: back to DIV1, aux holds
    drive(0, 1, 1, 8'h99, 0);
    drive(0, 0, 1, 8'h9A, 0);
    // constrained random with rare mode changes
    for (int i = 0; i < 3000; i++) begin
      logic e, s;
      e = en; s = sel;
      if ($urandom_range(0, 49) == 0) begin e = $urandom_range(0, 1); s = $urandom_range(0, 1); end
      drive(e, s, ($urandom_range(0, 3) != 0), 8'($urandom), ($urandom_range(0, 7) == 0));
      if (i == 1500) begin
        do_reset();  // R8: marker again after a second reset
      end
    end
    finish_run();
  end
endmodule